// File: doc/BRIEF.md
# PCI Type-0 Configuration Space Register File

This block holds the 256-byte configuration space of a single PCI function with a type-0 header. A host-side agent reaches it through one access port that carries a byte offset, a transfer size of one, two or four bytes, a write flag and write data. Reads answer one cycle later on a response port. The function's identity fields, the sizes and kinds of its six base address registers, the size of its expansion ROM and the reset value of the status word are fixed by parameters.

Each byte has its own write behaviour. Identity bytes and the BAR and ROM windows ignore ordinary writes. The two status bytes clear only the bits written as one. Every other byte takes the written value. A BAR or the ROM register is loaded only by an aligned four-byte write to its own offset. The stored value keeps only the address bits above the region size, plus the type bit for a BAR or the enable bit for the ROM. For each BAR and for the ROM, the block drives a decode-enable flag from the command byte, together with the base address with its low bits cleared. The base address reads as zero while the region is not decoding.

Top module: `cfgspace_regfile`

## Requirements
- R1: After reset, bytes 0x00-0x01 hold the vendor ID, 0x02-0x03 the device ID, 0x08 the revision, 0x0A-0x0B the class code and 0x0E the header type 0x00, all little-endian. 0x06-0x07 hold the status reset value. An I/O BAR holds 0x00000001, every other BAR and the ROM register hold zero, and all decode enables are low.
- R2: Writes to bytes 0x00-0x03, 0x08-0x0B, 0x0E, 0x10-0x27, 0x30-0x33 and 0x3D leave them unchanged, except for the register write of R5 and R6.
- R3: A write covering byte 0x06 or 0x07 clears the bits of that byte where the write data is one and keeps every other bit.
- R4: Every other byte stores the written byte. A two- or four-byte write is applied one byte at a time with little-endian order, and any byte that would land past offset 0xFF is dropped.
- R5: A four-byte write at 0x10+4*n (n = 0..5) to a BAR of nonzero size S stores (data AND NOT (S-1)) OR the type bit. The type bit is bit 0 = 1 for an I/O BAR and 0 for a memory BAR.
- R6: A four-byte write at 0x30 with a nonzero ROM size S stores (data AND NOT (S-1)) with bit 0 taken from the data.
- R7: A BAR of size zero reads as zero and stays zero under writes of any size.
- R8: Command byte 0x04 bit 0 enables the I/O BARs and bit 1 enables the memory BARs. The ROM decodes only when bit 1 and ROM register bit 0 are both one. An enabled region outputs its register with the low log2(S) bits cleared, a disabled one outputs zero, and the outputs change only after a write.
- R9: A read returns rsp_valid and rsp_data on the cycle after the request. Size code 0 reads one byte, and code 1 reads two bytes from any offset, except at 0xFF where it returns that byte alone. Codes 2 and 3 read four bytes with the offset's two low bits ignored (writes align the same way). Unused high bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset into configuration space |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| req_wdata | input | 32 | Write data, lowest byte goes to the lowest offset |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_data | output | 32 | Read data, zero-extended |
| bar_en | output | 6 | Decode enable per BAR |
| bar_base | output | 192 | Masked base per BAR, BAR n in bits 32n+31:32n |
| rom_en | output | 1 | Expansion ROM decode enable |
| rom_base | output | 32 | Masked ROM base address |

## Verification
The bench builds the block with BAR0 as a 32-byte I/O region, BAR1 as a 4 KiB memory region, BAR3 at the 4-byte minimum, BAR5 as a 256-byte memory region that is never programmed, BAR2 and BAR4 unused, and a 2 KiB ROM. This mix covers the type bit on an I/O BAR, masking at the smallest and at a mid-range size, and both fall-through paths on an unused slot. It also shows a memory BAR that decodes at base zero when only the command bit is set. The nonzero status reset value makes partial clearing of the status bits visible. Distinct identity bytes expose any byte swap in the read path.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;

    localparam int CFG_BYTES = 256;
    localparam int NUM_BARS  = 6;

    localparam logic [7:0] OFF_CMD     = 8'h04;
    localparam logic [7:0] OFF_STAT_LO = 8'h06;
    localparam logic [7:0] OFF_STAT_HI = 8'h07;
    localparam logic [7:0] OFF_BAR0    = 8'h10;
    localparam logic [7:0] OFF_ROM     = 8'h30;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_e;

    typedef struct packed {
        logic       valid;
        logic       write;
        logic [7:0] addr;
        xfer_size_e size;
        logic [31:0] wdata;
    } cfg_req_t;

    typedef logic [CFG_BYTES-1:0][7:0] cfg_image_t;

    // Bytes that ordinary (byte-wise) writes must not change
    function automatic logic is_ro_byte(input logic [7:0] a);
        return (a <= 8'h03) ||
               (a >= 8'h08 && a <= 8'h0B) ||
               (a == 8'h0E) ||
               (a >= 8'h10 && a <= 8'h27) ||
               (a >= 8'h30 && a <= 8'h33) ||
               (a == 8'h3D);
    endfunction

    function automatic logic [2:0] xfer_bytes(input xfer_size_e s);
        case (s)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // Four-byte accesses are always treated as aligned
    function automatic logic [7:0] eff_addr(input logic [7:0] a, input xfer_size_e s);
        return (xfer_bytes(s) == 3'd4) ? {a[7:2], 2'b00} : a;
    endfunction

endpackage

// File: rtl/cfgsp_write_unit.sv
module cfgsp_write_unit
    import cfgsp_pkg::*;
#(
    parameter logic [NUM_BARS-1:0][31:0] BAR_SIZE = '0,
    parameter logic [NUM_BARS-1:0]       BAR_IO   = '0,
    parameter logic [31:0]               ROM_SIZE = '0
) (
    input  cfg_req_t   req,
    input  cfg_image_t cur,
    output cfg_image_t nxt
);

    logic [7:0]  ea;
    logic        word_acc;
    logic        reg_hit;
    logic [31:0] reg_val;

    // Register (BAR / ROM) write detection and value shaping
    always_comb begin
        ea       = eff_addr(req.addr, req.size);
        word_acc = (xfer_bytes(req.size) == 3'd4);
        reg_hit  = 1'b0;
        reg_val  = '0;
        for (int n = 0; n < NUM_BARS; n++) begin
            if (word_acc && (ea == OFF_BAR0 + 8'(4 * n)) && (BAR_SIZE[n] != 32'd0)) begin
                reg_hit = 1'b1;
                reg_val = (req.wdata & ~(BAR_SIZE[n] - 32'd1)) | {31'd0, BAR_IO[n]};
            end
        end
        if (word_acc && (ea == OFF_ROM) && (ROM_SIZE != 32'd0)) begin
            reg_hit = 1'b1;
            reg_val = (req.wdata & ~(ROM_SIZE - 32'd1)) | {31'd0, req.wdata[0]};
        end
    end

    // Next image: register write or per-byte protected write
    always_comb begin
        logic [8:0] a9;
        logic [7:0] ba;
        logic [7:0] d;
        a9  = '0;
        ba  = '0;
        d   = '0;
        nxt = cur;
        if (req.valid && req.write) begin
            if (reg_hit) begin
                for (int k = 0; k < 4; k++) begin
                    nxt[ea + 8'(k)] = reg_val[8*k +: 8];
                end
            end else begin
                for (int k = 0; k < 4; k++) begin
                    a9 = {1'b0, ea} + 9'(k);
                    ba = a9[7:0];
                    d  = req.wdata[8*k +: 8];
                    if ((3'(k) < xfer_bytes(req.size)) && !a9[8]) begin
                        if (ba == OFF_STAT_LO || ba == OFF_STAT_HI) begin
                            nxt[ba] = cur[ba] & ~d;
                        end else if (!is_ro_byte(ba)) begin
                            nxt[ba] = d;
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/cfgsp_decode.sv
module cfgsp_decode
    import cfgsp_pkg::*;
#(
    parameter logic [NUM_BARS-1:0][31:0] BAR_SIZE = '0,
    parameter logic [NUM_BARS-1:0]       BAR_IO   = '0,
    parameter logic [31:0]               ROM_SIZE = '0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [7:0]                    cmd,
    input  logic [NUM_BARS-1:0][31:0]     bar_reg,
    input  logic [31:0]                   rom_reg,
    output logic [NUM_BARS-1:0]           bar_en,
    output logic [NUM_BARS-1:0][31:0]     bar_base,
    output logic                          rom_en,
    output logic [31:0]                   rom_base
);

    localparam logic [31:0] ROM_MASK = ~(ROM_SIZE - 32'd1);

    for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
        localparam logic [31:0] MASK = ~(BAR_SIZE[g] - 32'd1);
        localparam bit          USED = (BAR_SIZE[g] != 32'd0);

        assign bar_en[g]   = USED && (BAR_IO[g] ? cmd[0] : cmd[1]);
        assign bar_base[g] = bar_en[g] ? (bar_reg[g] & MASK) : 32'd0;

        // R8: the base handed to the decoder never carries bits below the size
        assert_base_aligned_R8: assert property (@(posedge clk) disable iff (rst)
            (bar_base[g] & ~MASK) == 32'd0)
            else $error("BAR %0d base not aligned to its size", g);
    end

    assign rom_en   = (ROM_SIZE != 32'd0) && cmd[1] && rom_reg[0];
    assign rom_base = rom_en ? (rom_reg & ROM_MASK) : 32'd0;

    // R6: ROM base leaves out the enable bit and the size bits
    assert_rom_base_clean_R6: assert property (@(posedge clk) disable iff (rst)
        (rom_base & ~ROM_MASK) == 32'd0)
        else $error("ROM base carries low bits");

endmodule

// File: rtl/cfgsp_read_port.sv
module cfgsp_read_port
    import cfgsp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  cfg_req_t    req,
    input  cfg_image_t  img,
    output logic        rsp_valid,
    output logic [31:0] rsp_data
);

    logic [7:0]  ea;
    logic [31:0] rd_next;
    logic        rd_req;

    assign rd_req = req.valid && !req.write;

    always_comb begin
        ea = eff_addr(req.addr, req.size);
        case (xfer_bytes(req.size))
            3'd1:    rd_next = {24'd0, img[ea]};
            3'd2:    rd_next = (ea == 8'hFF) ? {24'd0, img[ea]}
                                             : {16'd0, img[ea + 8'd1], img[ea]};
            default: rd_next = {img[ea + 8'd3], img[ea + 8'd2], img[ea + 8'd1], img[ea]};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= rd_req;
            if (rd_req) begin
                rsp_data <= rd_next;
            end
        end
    end

    // R9: exactly one response, one cycle after each read request
    assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rsp_valid)
        else $error("read without response");
    assert_rsp_spurious_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rsp_valid)
        else $error("response without read");

endmodule

// File: rtl/cfgspace_regfile.sv
module cfgspace_regfile
    import cfgsp_pkg::*;
#(
    parameter logic [15:0]               VENDOR_ID    = 16'hABCD,
    parameter logic [15:0]               DEVICE_ID    = 16'h4321,
    parameter logic [7:0]                REVISION     = 8'h05,
    parameter logic [15:0]               CLASS_CODE   = 16'h0580,
    parameter logic [15:0]               STATUS_RESET = 16'h0290,
    parameter logic [NUM_BARS-1:0][31:0] BAR_SIZE     = {32'd256, 32'd0, 32'd4, 32'd0, 32'd4096, 32'd32},
    parameter logic [NUM_BARS-1:0]       BAR_IO       = 6'b000001,
    parameter logic [31:0]               ROM_SIZE     = 32'd2048
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [7:0]             req_addr,
    input  logic [1:0]             req_size,
    input  logic [31:0]            req_wdata,
    output logic                   rsp_valid,
    output logic [31:0]            rsp_data,
    output logic [NUM_BARS-1:0]    bar_en,
    output logic [NUM_BARS*32-1:0] bar_base,
    output logic                   rom_en,
    output logic [31:0]            rom_base
);

    cfg_req_t   req;
    cfg_image_t mem;
    cfg_image_t mem_nx;
    cfg_image_t rst_img;

    logic [NUM_BARS-1:0][31:0] bar_reg;
    logic [NUM_BARS-1:0][31:0] bar_base_pk;
    logic [31:0]               rom_reg;

    assign req = '{valid: req_valid, write: req_write, addr: req_addr,
                   size: xfer_size_e'(req_size), wdata: req_wdata};

    // Reset image built from the identity parameters
    always_comb begin
        rst_img        = '0;
        rst_img[8'h00] = VENDOR_ID[7:0];
        rst_img[8'h01] = VENDOR_ID[15:8];
        rst_img[8'h02] = DEVICE_ID[7:0];
        rst_img[8'h03] = DEVICE_ID[15:8];
        rst_img[8'h06] = STATUS_RESET[7:0];
        rst_img[8'h07] = STATUS_RESET[15:8];
        rst_img[8'h08] = REVISION;
        rst_img[8'h0A] = CLASS_CODE[7:0];
        rst_img[8'h0B] = CLASS_CODE[15:8];
        rst_img[8'h0E] = 8'h00;
        for (int n = 0; n < NUM_BARS; n++) begin
            rst_img[OFF_BAR0 + 8'(4 * n)] = {7'd0, (BAR_SIZE[n] != 32'd0) && BAR_IO[n]};
        end
    end

    cfgsp_write_unit #(
        .BAR_SIZE (BAR_SIZE),
        .BAR_IO   (BAR_IO),
        .ROM_SIZE (ROM_SIZE)
    ) u_write (
        .req (req),
        .cur (mem),
        .nxt (mem_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= rst_img;
        end else begin
            mem <= mem_nx;
        end
    end

    for (genvar g = 0; g < NUM_BARS; g++) begin : g_breg
        localparam int B = 16 + 4 * g;
        assign bar_reg[g] = {mem[B + 3], mem[B + 2], mem[B + 1], mem[B]};
    end
    assign rom_reg = {mem[8'h33], mem[8'h32], mem[8'h31], mem[8'h30]};

    cfgsp_decode #(
        .BAR_SIZE (BAR_SIZE),
        .BAR_IO   (BAR_IO),
        .ROM_SIZE (ROM_SIZE)
    ) u_decode (
        .clk      (clk),
        .rst      (rst),
        .cmd      (mem[OFF_CMD]),
        .bar_reg  (bar_reg),
        .rom_reg  (rom_reg),
        .bar_en   (bar_en),
        .bar_base (bar_base_pk),
        .rom_en   (rom_en),
        .rom_base (rom_base)
    );
    assign bar_base = bar_base_pk;

    cfgsp_read_port u_read (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .img       (mem),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    // R2: identity bytes never move after reset
    assert_ident_stable_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable({mem[8'h0E], mem[8'h0B], mem[8'h0A], mem[8'h08],
                          mem[8'h03], mem[8'h02], mem[8'h01], mem[8'h00]}))
        else $error("identity byte changed");

    // R3: status bits can only fall, never rise
    assert_status_no_set_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (({mem[OFF_STAT_HI], mem[OFF_STAT_LO]} &
                   ~$past({mem[OFF_STAT_HI], mem[OFF_STAT_LO]})) == 16'd0))
        else $error("status bit set by a write");

    // R8: decode outputs hold while no write arrives
    assert_en_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_write) |=> ($stable(bar_en) && $stable(rom_en) &&
                                       $stable(bar_base) && $stable(rom_base)))
        else $error("decode output moved without a write");

endmodule

// File: tb/cfgspace_regfile_test.sv
`timescale 1ns/1ps
module cfgspace_regfile_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [7:0]   req_addr = '0;
    logic [1:0]   req_size = '0;
    logic [31:0]  req_wdata = '0;
    logic         rsp_valid;
    logic [31:0]  rsp_data;
    logic [5:0]   bar_en;
    logic [191:0] bar_base;
    logic         rom_en;
    logic [31:0]  rom_base;

    int checks = 0;
    int failures = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    cfgspace_regfile #(
        .VENDOR_ID    (16'hABCD),
        .DEVICE_ID    (16'h4321),
        .REVISION     (8'h05),
        .CLASS_CODE   (16'h0580),
        .STATUS_RESET (16'h0290),
        .BAR_SIZE     ({32'd256, 32'd0, 32'd4, 32'd0, 32'd4096, 32'd32}),
        .BAR_IO       (6'b000001),
        .ROM_SIZE     (32'd2048)
    ) uut (
        .clk, .rst, .req_valid, .req_write, .req_addr, .req_size, .req_wdata,
        .rsp_valid, .rsp_data, .bar_en, .bar_base, .rom_en, .rom_base
    );

    always #4 clk = ~clk;

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = s; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [1:0] s,
                      input logic [31:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = s;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL R9 unexpected response actual=%h expected=none", rsp_data);
            end else begin
                cmp(tag_q.pop_front(), rsp_data, exp_q.pop_front());
            end
        end
    end

    task automatic chk_dec(input string tag, input logic [5:0] en, input logic ren,
                           input logic [31:0] b0, input logic [31:0] b1,
                           input logic [31:0] b3, input logic [31:0] rb);
        cmp({tag, " bar_en"}, {26'd0, bar_en}, {26'd0, en});
        cmp({tag, " rom_en"}, {31'd0, rom_en}, {31'd0, ren});
        cmp({tag, " base0"}, bar_base[0 +: 32], b0);
        cmp({tag, " base1"}, bar_base[32 +: 32], b1);
        cmp({tag, " base2"}, bar_base[64 +: 32], 32'd0);
        cmp({tag, " base3"}, bar_base[96 +: 32], b3);
        cmp({tag, " base5"}, bar_base[160 +: 32], 32'd0);
        cmp({tag, " rom_base"}, rom_base, rb);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        cmp("R1 rsp_valid idle", {31'd0, rsp_valid}, 32'd0);
        chk_dec("R1 reset decode", 6'b000000, 1'b0, 32'd0, 32'd0, 32'd0, 32'd0);
        rd(8'h00, 2'd2, 32'h4321ABCD, "R1 ids");
        rd(8'h08, 2'd2, 32'h05800005, "R1 rev/class");
        rd(8'h0E, 2'd0, 32'h00000000, "R1 header type");
        rd(8'h06, 2'd1, 32'h00000290, "R1 status reset");
        rd(8'h10, 2'd2, 32'h00000001, "R1 io bar reset");
        rd(8'h14, 2'd2, 32'h00000000, "R1 mem bar reset");

        // R2: read-only bytes
        wr(8'h00, 2'd2, 32'hFFFFFFFF);
        rd(8'h00, 2'd2, 32'h4321ABCD, "R2 id word write");
        wr(8'h0E, 2'd0, 32'h000000FF);
        rd(8'h0E, 2'd0, 32'h00000000, "R2 header byte write");
        wr(8'h3C, 2'd1, 32'h00007F0E);
        rd(8'h3C, 2'd1, 32'h0000000E, "R2 0x3D protected, R4 0x3C written");

        // R3: status write-one-to-clear
        wr(8'h06, 2'd1, 32'h00000210);
        rd(8'h06, 2'd1, 32'h00000080, "R3 partial clear");
        wr(8'h07, 2'd0, 32'h000000FF);
        rd(8'h06, 2'd1, 32'h00000080, "R3 high byte clear no effect");
        wr(8'h06, 2'd0, 32'h00000080);
        rd(8'h06, 2'd1, 32'h00000000, "R3 last bit cleared");

        // R4 / R9: byte-wise writes and read sizes
        wr(8'h40, 2'd2, 32'h11223344);
        rd(8'h41, 2'd0, 32'h00000033, "R4 byte lane");
        rd(8'h41, 2'd1, 32'h00002233, "R9 unaligned half");
        rd(8'h42, 2'd2, 32'h11223344, "R9 word align");
        rd(8'h43, 2'd3, 32'h11223344, "R9 size code 3");
        wr(8'hFF, 2'd1, 32'h0000A55A);
        rd(8'hFF, 2'd1, 32'h0000005A, "R9 half at 0xFF");
        rd(8'h00, 2'd0, 32'h000000CD, "R4 no wrap past 0xFF");

        // R5: BAR writes
        wr(8'h10, 2'd2, 32'hFFFFFFFF);
        rd(8'h10, 2'd2, 32'hFFFFFFE1, "R5 io bar mask+type");
        wr(8'h14, 2'd2, 32'h12345678);
        rd(8'h14, 2'd2, 32'h12345000, "R5 mem bar 4K mask");
        wr(8'h1C, 2'd2, 32'hFFFFFFFF);
        rd(8'h1C, 2'd2, 32'hFFFFFFFC, "R5 min size bar");
        wr(8'h10, 2'd0, 32'h00000000);
        rd(8'h10, 2'd2, 32'hFFFFFFE1, "R5 byte write to bar ignored");
        wr(8'h12, 2'd1, 32'h00000000);
        rd(8'h10, 2'd2, 32'hFFFFFFE1, "R5 half write to bar ignored");

        // R7: unused BAR
        wr(8'h18, 2'd2, 32'hFFFFFFFF);
        rd(8'h18, 2'd2, 32'h00000000, "R7 unused bar word");
        wr(8'h18, 2'd0, 32'h000000FF);
        rd(8'h18, 2'd2, 32'h00000000, "R7 unused bar byte");

        // R8: decode enables
        chk_dec("R8 cmd zero", 6'b000000, 1'b0, 32'd0, 32'd0, 32'd0, 32'd0);
        wr(8'h04, 2'd0, 32'h00000001);
        chk_dec("R8 io only", 6'b000001, 1'b0, 32'hFFFFFFE0, 32'd0, 32'd0, 32'd0);
        wr(8'h04, 2'd0, 32'h00000002);
        chk_dec("R8 mem only", 6'b101010, 1'b0, 32'd0, 32'h12345000, 32'hFFFFFFFC, 32'd0);

        // R6: ROM register and its enable
        wr(8'h30, 2'd2, 32'hFFFFFFFF);
        rd(8'h30, 2'd2, 32'hFFFFF801, "R6 rom mask keep bit0");
        chk_dec("R8 rom on", 6'b101010, 1'b1, 32'd0, 32'h12345000, 32'hFFFFFFFC, 32'hFFFFF800);
        wr(8'h30, 2'd2, 32'hABCDE7FE);
        rd(8'h30, 2'd2, 32'hABCDE000, "R6 rom bit0 clear");
        chk_dec("R8 rom bit0 off", 6'b101010, 1'b0, 32'd0, 32'h12345000, 32'hFFFFFFFC, 32'd0);
        wr(8'h30, 2'd2, 32'h00010001);
        wr(8'h04, 2'd2, 32'h00000003);
        rd(8'h04, 2'd2, 32'h00000003, "R3 zero write keeps cleared status, R4 cmd");
        chk_dec("R8 both", 6'b101011, 1'b1, 32'hFFFFFFE0, 32'h12345000, 32'hFFFFFFFC, 32'h00010000);
        wr(8'h04, 2'd0, 32'h00000000);
        chk_dec("R8 all off", 6'b000000, 1'b0, 32'd0, 32'd0, 32'd0, 32'd0);

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R9 missing responses actual=%0d expected=0", exp_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule